// File: doc/BRIEF.md
# Programmable Interrupt Aggregator

This block gathers interrupt events from six sources and drives one external interrupt pin. Five sources are hardware event inputs: time-stamp unit, switch fabric, Ethernet PHYs, GPIOs and the general purpose timer. The sixth is raised by software. Each event sets a sticky bit in a pending-status register. An enable register selects which pending bits may drive the pin. Software clears pending bits by writing ones to them.

A configuration register sets the pin's active level, whether the pad is driven push-pull or open-drain, and a minimum idle interval. After the pin is released, it stays released for that interval before it may assert again. The interval is counted in ticks of `TICK_CYCLES` clock cycles, which is 10 µs at 100 MHz with the default value. The register interface is a plain single-cycle write strobe with a combinational read. Reads have no side effects. Register map, with 16-bit data:
- Address 0: pending status. Reading returns the bits; writing a 1 clears that bit.
- Address 1: enable mask.
- Address 2: configuration.
- Address 3: software trigger. Writing a 1 to bit 0 raises the software source. Reading returns 0.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, status, enable and configuration are all zero. The pin is therefore active-low, open-drain and released: `irq_out`=1, `irq_oe`=0, and every register reads 0.
- R2: A high level on `src_evt[i]` (i = 0..4: time-stamp, fabric, PHY, GPIO, timer) at a clock edge sets status bit i. That bit is read at address 0 after the edge and stays set after the input drops.
- R3: Writing address 0 clears every status bit whose data bit is 1. Status bits written with 0 keep their value.
- R4: Writing address 3 with data bit 0 = 1 sets status bit 5 (the software source). Address 3 always reads 0.
- R5: Configuration bit 7 is read-only. It reads 1 exactly when (status AND enable) is non-zero. Masked pending bits do not drive the pin. The pin asserts one clock after that flag rises, unless the idle interval is still running.
- R6: Configuration bit 0 selects the active level. With 0, the asserted pin is low and the released pin is high. With 1, the asserted pin is high and the released pin is low.
- R7: Configuration bit 1 selects the buffer type. With 1 (push-pull), `irq_oe` is always 1. With 0 (open-drain), `irq_oe` is 1 only while the pin is asserted.
- R8: Configuration bits 15:8 hold an idle interval G. G is captured when the pin releases. For the next G×`TICK_CYCLES` clocks the pin stays released, even if the internal flag is high. It may assert at the following edge.
- R9: If a source event and a write-one-clear hit the same status bit on the same edge, the bit ends up set.
- R10: The pin releases one clock after the internal flag falls. The flag falls through a clear or by disabling the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 5 | Hardware source events, bit 0 time-stamp .. bit 4 timer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq_out | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The hardest situation to reach is a source that is pending and enabled while the idle interval is still running. To reach it, the bench first sets a non-zero interval. It then clears the only pending bit, which releases the pin, and raises a new event within a few clocks. The pin must stay released through the whole interval and assert on the first allowed edge. A second hard case is a clear and an event landing on the same bit on the same edge. The bench drives the write strobe and the source input together in one cycle. A behavioural model checks the pin, the output enable and the read data on every clock.

// File: rtl/irq_agg_pkg.sv
// Shared constants for the interrupt aggregator: source indices,
// register addresses and configuration field positions.
package irq_agg_pkg;
    localparam int NUM_SRC  = 6;
    localparam int NUM_HW   = NUM_SRC - 1;
    localparam int DATA_W   = 16;
    localparam int GAP_W    = 8;

    localparam int SRC_SW   = 5;

    typedef enum logic [1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_ENABLE = 2'd1,
        ADDR_CONFIG = 2'd2,
        ADDR_SWTRIG = 2'd3
    } reg_addr_e;

    localparam int CFG_POL_BIT  = 0;
    localparam int CFG_PP_BIT   = 1;
    localparam int CFG_INT_BIT  = 7;
    localparam int CFG_GAP_LSB  = 8;

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic             push_pull;
        logic             active_high;
    } irq_cfg_t;
endpackage

// File: rtl/irq_agg_status.sv
// Pending-status bank. Each bit is sticky: a set request wins over a clear
// request on the same edge. Assumes clr and set are single-cycle strobes
// qualified by the caller.
module irq_agg_status #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold, clear or set one pending bit; set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
            end else if (set_req[i]) begin
                status[i] <= 1'b1;
            end else if (clr_req[i]) begin
                status[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_agg_gate.sv
// Pin-state sequencer. Tracks whether the interrupt pin is asserted, and
// after each release it counts GAP ticks of TICK_CYCLES clocks during which
// the pin may not assert. Assumes gap_cfg is stable enough to be sampled
// once, at the release edge.
module irq_agg_gate #(
    parameter int TICK_CYCLES = 1000,
    parameter int GAP_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_irq,
    input  logic [GAP_W-1:0] gap_cfg,
    output logic             active,
    output logic             gap_busy
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] TICK_LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0]    presc;
    logic [GAP_W-1:0] gap_cnt;
    logic             release_now;

    assign gap_busy    = (gap_cnt != '0);
    assign release_now = active && !int_irq;

    // Assert when allowed, release when the internal flag drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (active) begin
            active <= int_irq;
        end else begin
            active <= int_irq && !gap_busy;
        end
    end

    // Load the idle interval on release and count it down in ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            presc   <= '0;
        end else if (release_now) begin
            gap_cnt <= gap_cfg;
            presc   <= '0;
        end else if (gap_busy) begin
            if (presc == TICK_LAST) begin
                presc   <= '0;
                gap_cnt <= gap_cnt - 1'b1;
            end else begin
                presc   <= presc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_agg_pin.sv
// Pad control: maps the asserted state to a pin level and an output enable
// according to polarity and buffer type. Purely combinational.
module irq_agg_pin (
    input  logic active,
    input  logic active_high,
    input  logic push_pull,
    output logic pin_level,
    output logic pin_oe
);
    // Level follows polarity; open-drain drives only while asserted.
    always_comb begin
        pin_level = active_high ? active : !active;
        pin_oe    = push_pull | active;
    end
endmodule

// File: rtl/irq_aggregator.sv
// Interrupt aggregator top. Latches five hardware events plus a software
// event into sticky status, masks them with an enable register and drives
// one interrupt pin with programmable level, buffer type and minimum idle
// interval. Assumes a single-cycle write strobe and a combinational read.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int TICK_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] src_evt,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out,
    output logic              irq_oe
);
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] set_req;
    logic [NUM_SRC-1:0] clr_req;
    irq_cfg_t           cfg;
    logic               int_irq;
    logic               irq_active;
    logic               gap_busy;
    logic               wr_status, wr_enable, wr_config, wr_swtrig;

    // Decode the write strobe per register.
    always_comb begin
        wr_status = reg_wr && (reg_addr == ADDR_STATUS);
        wr_enable = reg_wr && (reg_addr == ADDR_ENABLE);
        wr_config = reg_wr && (reg_addr == ADDR_CONFIG);
        wr_swtrig = reg_wr && (reg_addr == ADDR_SWTRIG);
    end

    // Build the per-bit set and clear requests for the status bank.
    always_comb begin
        set_req         = {1'b0, src_evt};
        set_req[SRC_SW] = wr_swtrig && reg_wdata[0];
        clr_req         = wr_status ? reg_wdata[NUM_SRC-1:0] : '0;
    end

    irq_agg_status #(.N(NUM_SRC)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .status  (status)
    );

    // Enable mask and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
            cfg    <= '0;
        end else begin
            if (wr_enable) begin
                enable <= reg_wdata[NUM_SRC-1:0];
            end
            if (wr_config) begin
                cfg.active_high <= reg_wdata[CFG_POL_BIT];
                cfg.push_pull   <= reg_wdata[CFG_PP_BIT];
                cfg.gap         <= reg_wdata[CFG_GAP_LSB +: GAP_W];
            end
        end
    end

    assign int_irq = |(status & enable);

    irq_agg_gate #(.TICK_CYCLES(TICK_CYCLES), .GAP_W(GAP_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_irq  (int_irq),
        .gap_cfg  (cfg.gap),
        .active   (irq_active),
        .gap_busy (gap_busy)
    );

    irq_agg_pin u_pin (
        .active      (irq_active),
        .active_high (cfg.active_high),
        .push_pull   (cfg.push_pull),
        .pin_level   (irq_out),
        .pin_oe      (irq_oe)
    );

    // Combinational register read mux.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STATUS: reg_rdata[NUM_SRC-1:0] = status;
            ADDR_ENABLE: reg_rdata[NUM_SRC-1:0] = enable;
            ADDR_CONFIG: begin
                reg_rdata[CFG_POL_BIT]               = cfg.active_high;
                reg_rdata[CFG_PP_BIT]                = cfg.push_pull;
                reg_rdata[CFG_INT_BIT]               = int_irq;
                reg_rdata[CFG_GAP_LSB +: GAP_W]      = cfg.gap;
            end
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
// Assertion checker for irq_aggregator, attached by bind below.
module irq_aggregator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  src_evt,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic [5:0]  status,
    input logic        int_irq,
    input logic        irq_active,
    input logic        gap_busy,
    input logic        push_pull,
    input logic        irq_oe
);
    // R2: a hardware event sets its status bit.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != 5'd0) |=> ((status[4:0] & $past(src_evt)) == $past(src_evt)));

    // R3: a clear with no competing event empties the written bits.
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && src_evt == 5'd0)
        |=> ((status & $past(reg_wdata[5:0])) == 6'd0));

    // R9: event wins over a same-cycle clear.
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && (reg_wdata[4:0] & src_evt) != 5'd0)
        |=> ((status[4:0] & $past(reg_wdata[4:0] & src_evt)) == $past(reg_wdata[4:0] & src_evt)));

    // R5: the pin only asserts after the internal flag was high.
    a_r5_assert_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_active) |-> $past(int_irq));

    // R8: no assertion while the idle interval runs.
    a_r8_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        gap_busy |=> !irq_active);

    // R10: release one clock after the flag falls.
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_active && !int_irq) |=> !irq_active);

    // R7: open-drain leaves the pad undriven while released.
    a_r7_od_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_pull && !irq_active) |-> !irq_oe);
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_evt    (src_evt),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .status     (status),
    .int_irq    (int_irq),
    .irq_active (irq_active),
    .gap_busy   (gap_busy),
    .push_pull  (cfg.push_pull),
    .irq_oe     (irq_oe)
);

// File: tb/irq_aggregator_bench.sv
// Bench: behavioural reference model compared on every clock.
module irq_aggregator_bench;
    localparam int TICK = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_evt = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out, irq_oe;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    bit [5:0] m_status, m_en;
    bit       m_pol, m_pp, m_active;
    int       m_gap, m_gap_left;

    always #5 clk = ~clk;

    irq_aggregator #(.TICK_CYCLES(TICK)) u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    function automatic bit m_int();
        return (m_status & m_en) != 6'd0;
    endfunction

    function automatic logic [15:0] m_rdata(input logic [1:0] a);
        logic [15:0] r = '0;
        case (a)
            2'd0: r[5:0] = m_status;
            2'd1: r[5:0] = m_en;
            2'd2: begin
                r[0] = m_pol; r[1] = m_pp; r[7] = m_int(); r[15:8] = 8'(m_gap);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_edge();
        bit [5:0] clr, set;
        bit       flag;
        if (!rst_n) begin
            m_status = 0; m_en = 0; m_pol = 0; m_pp = 0; m_gap = 0;
            m_active = 0; m_gap_left = 0;
            return;
        end
        flag = m_int();
        if (m_active) begin
            if (!flag) begin m_active = 0; m_gap_left = m_gap * TICK; end
        end else if (m_gap_left > 0) begin
            m_gap_left--;
        end else if (flag) begin
            m_active = 1;
        end
        clr = (reg_wr && reg_addr == 2'd0) ? reg_wdata[5:0] : 6'd0;
        set = {(reg_wr && reg_addr == 2'd3 && reg_wdata[0]), src_evt};
        m_status = (m_status & ~clr) | set;
        if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata[5:0];
        if (reg_wr && reg_addr == 2'd2) begin
            m_pol = reg_wdata[0]; m_pp = reg_wdata[1]; m_gap = int'(reg_wdata[15:8]);
        end
    endtask

    task automatic compare();
        bit       e_out = m_pol ? m_active : !m_active;
        bit       e_oe  = m_pp | m_active;
        logic [15:0] e_rd = m_rdata(reg_addr);
        vectors++;
        if (irq_out !== e_out || irq_oe !== e_oe || reg_rdata !== e_rd) begin
            miscompares++;
            $display("FAIL %s: out=%b oe=%b rdata=%h expected out=%b oe=%b rdata=%h",
                     tag, irq_out, irq_oe, reg_rdata, e_out, e_oe, e_rd);
        end
    endtask

    // One clock: inputs already driven, model updated at edge, compare after.
    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        src_evt = '0; reg_wr = 1'b0;
    endtask

    task automatic idle(input int n, input logic [1:0] a);
        for (int k = 0; k < n; k++) begin
            reg_addr = a;
            cycle();
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cycle();
    endtask

    initial begin
        @(negedge clk);
        tag = "R1 reset";
        idle(3, 2'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) idle(1, 2'(a));

        tag = "R2 event sets sticky";
        src_evt = 5'b00100; cycle();
        idle(3, 2'd0);
        tag = "R5 masked pending";
        idle(3, 2'd2);

        tag = "R5 enable drives pin";
        wr(2'd1, 16'h003f);
        idle(4, 2'd2);

        tag = "R3 clear wrong bit";
        wr(2'd0, 16'h0001);
        idle(3, 2'd0);
        tag = "R10 clear releases";
        wr(2'd0, 16'h0004);
        idle(3, 2'd2);

        tag = "R6 R7 high push-pull";
        wr(2'd2, 16'h0303);
        tag = "R4 software trigger";
        wr(2'd3, 16'h0001);
        idle(3, 2'd3);
        idle(2, 2'd0);

        tag = "R8 idle interval";
        wr(2'd0, 16'h0020);
        src_evt = 5'b00001; cycle();
        idle(3 * TICK + 4, 2'd2);

        tag = "R9 event vs clear";
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h001f; src_evt = 5'b10000;
        cycle();
        idle(3, 2'd0);

        tag = "R7 open-drain low";
        wr(2'd2, 16'h0000);
        idle(3, 2'd2);
        wr(2'd1, 16'h0000);
        tag = "R10 disable releases";
        idle(3, 2'd2);
        tag = "R8 zero interval";
        wr(2'd1, 16'h0010);
        idle(3, 2'd0);

        tag = "R2 multi-source";
        src_evt = 5'b01010; cycle();
        src_evt = 5'b00001; cycle();
        idle(2, 2'd0);
        wr(2'd0, 16'h003f);
        idle(4, 2'd2);

        tag = "R1 reset mid-run";
        wr(2'd2, 16'h0503);
        src_evt = 5'b11111; cycle();
        rst_n = 1'b0; idle(2, 2'd1);
        rst_n = 1'b1; idle(2, 2'd0);
        idle(1, 2'd2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule